// File: doc/BRIEF.md
# Key and Strobe Trigger Controller

This block sits in front of a 32-group voice playback engine and turns slow, bouncy trigger pins into clean commands. It emits a one-cycle start pulse with a group index, a one-cycle stop request, and a level that shows a holdable group is being held. The engine answers with a one-cycle done pulse when a group finishes. All inputs are accepted only after they have been stable for a number of sample ticks. The sample tick is the engine's sampling-rate strobe.

A static configuration bit picks one of two ways of reading the pins. In key mode, eight active-high pins select a group: either one pin alone, or two neighbouring pins together. A separate button steps through the first sixteen groups in turn. In strobe mode, the low five pins carry a binary group address. That address is taken when the button (acting as a strobe) rises.

Each group has three option bits. They decide:
- whether holding the input repeats playback;
- whether letting go of the input stops it;
- whether a fresh trigger may cut into a playback that is already running.

Top module: `trig_ctl`

## Requirements
- R1: After reset, start_pulse, stop_req and hold_active are low. The sequential pointer points at group index 0, so the first accepted button press in key mode starts index 0.
- R2: In key mode, a debounced pin vector with only key_pins[i] high starts group index i (i = 0..7).
- R3: In key mode, a debounced pin vector with exactly key_pins[i] and key_pins[i+1] high starts group index 8+i (i = 0..6). Every other combination starts nothing.
- R4: In key mode, a debounced rising edge of seq_btn starts the group at the sequential pointer. The pointer then advances, wrapping from index 15 to index 0. It advances only on an accepted start. In strobe mode the pointer never moves.
- R5: In strobe mode, a debounced rising edge of seq_btn starts the group whose index is the binary value on key_pins[4:0]. The key pins alone start nothing.
- R6: The pin vector {seq_btn, key_pins} is accepted only after it has stayed unchanged for DEB_TICKS (128) sample ticks while idle, or RETRIG_TICKS (192) while playback is active. Shorter pulses are lost. Cycles without a tick do not count.
- R7: A trigger that arrives while playback is active is accepted only when the new group is level-mode and unholdable, or edge-mode and retriggerable. Otherwise it is ignored and playback continues. Option encoding: opt_edge bit = 1 for edge mode, opt_hold bit = 1 for holdable, opt_retrig bit = 1 for retriggerable.
- R8: For a holdable group, releasing the input that started it while active gives a one-cycle stop_req and ends the active state. stop_req never coincides with start_pulse.
- R9: When play_done arrives for a level-mode group whose input is still held, the same group restarts in the next cycle. An edge-mode group, or a released input, just goes idle.
- R10: hold_active is high exactly while a holdable group is active and its starting input is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strobe_mode | input | 1 | 0 = key mode, 1 = strobe mode (static) |
| sample_tick | input | 1 | One-cycle sampling-rate strobe that paces the debounce |
| key_pins | input | NPINS | Trigger pins, active high, bit 0 is the first pin |
| seq_btn | input | 1 | Sequential button in key mode, strobe in strobe mode |
| play_done | input | 1 | One-cycle pulse from the engine when the current group ends |
| opt_edge | input | NGROUPS | Per-group: 1 = edge trigger, 0 = level trigger |
| opt_hold | input | NGROUPS | Per-group: 1 = holdable |
| opt_retrig | input | NGROUPS | Per-group: 1 = retriggerable |
| start_pulse | output | 1 | One-cycle command to start a group |
| start_grp | output | clog2(NGROUPS) | Group index valid with start_pulse |
| stop_req | output | 1 | One-cycle command to stop playback |
| hold_active | output | 1 | A holdable group is active and held |

## Verification
Faults in the debounce counter show up at the ports as a start or stop that comes too early or too late. The expected latency is one input register plus the tick count plus two registers. A lost retrigger window shows as a start about 64 ticks early. A wrong sequential pointer, or wrong pin decoding, gives a wrong start_grp on the very next accepted press. A stuck active flag is caught one event later: a trigger that should have been ignored gets accepted, or one that should have been accepted is ignored, or a done pulse fails to loop a held level group.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int DEF_GROUPS       = 32;
    localparam int DEF_PINS         = 8;
    localparam int DEF_SEQ_LEN      = 16;
    localparam int DEF_DEB_TICKS    = 128;
    localparam int DEF_RETRIG_TICKS = 192;

    // Per-group trigger shaping
    typedef struct packed {
        logic is_edge;
        logic holdable;
        logic retrig;
    } grp_opt_t;

    // Origin of a trigger event
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_KEY  = 2'd1,
        SRC_SEQ  = 2'd2,
        SRC_STRB = 2'd3
    } trig_src_e;

    // A group may break into running playback only with these option pairs
    function automatic logic may_overlap(input grp_opt_t o);
        return (!o.is_edge && !o.holdable) || (o.is_edge && o.retrig);
    endfunction

endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
    parameter int W            = 9,
    parameter int DEB_TICKS    = 128,
    parameter int RETRIG_TICKS = 192
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         long_win,
    input  logic [W-1:0] raw,
    output logic [W-1:0] deb
);
    localparam int MAXT = (RETRIG_TICKS > DEB_TICKS) ? RETRIG_TICKS : DEB_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [W-1:0]  cand;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = long_win ? CW'(RETRIG_TICKS - 1) : CW'(DEB_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand <= '0;
            deb  <= '0;
            cnt  <= '0;
        end else if (raw != cand) begin
            cand <= raw;
            cnt  <= '0;
        end else if (cand == deb) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt >= limit) begin
                deb <= cand;
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/trig_decode.sv
module trig_decode #(
    parameter int NPINS = 8,
    parameter int GW    = 5
) (
    input  logic [NPINS-1:0] pins,
    output logic             valid,
    output logic [GW-1:0]    grp
);
    logic [NPINS-1:0] one_hit;
    logic [NPINS-2:0] two_hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_one
        assign one_hit[i] = (pins == (NPINS'(1) << i));
    end
    for (genvar i = 0; i < NPINS - 1; i++) begin : g_two
        assign two_hit[i] = (pins == (NPINS'(3) << i));
    end

    always_comb begin
        valid = 1'b0;
        grp   = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (one_hit[i]) begin
                valid = 1'b1;
                grp   = GW'(i);
            end
        end
        for (int i = 0; i < NPINS - 1; i++) begin
            if (two_hit[i]) begin
                valid = 1'b1;
                grp   = GW'(NPINS + i);
            end
        end
    end

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
    import trig_pkg::*;
#(
    parameter int NGROUPS = 32,
    parameter int SEQ_LEN = 16,
    parameter int GW      = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_press,
    input  logic [GW-1:0]      key_grp,
    input  logic               seq_press,
    input  logic               strb_press,
    input  logic [GW-1:0]      strb_grp,
    input  logic               key_now_valid,
    input  logic [GW-1:0]      key_now_grp,
    input  logic               btn_now,
    input  logic               play_done,
    input  logic [NGROUPS-1:0] opt_edge,
    input  logic [NGROUPS-1:0] opt_hold,
    input  logic [NGROUPS-1:0] opt_retrig,
    output logic               start_pulse,
    output logic [GW-1:0]      start_grp,
    output logic               stop_req,
    output logic               hold_active,
    output logic               active,
    output logic [GW-1:0]      seq_ptr
);
    trig_src_e     src;
    logic [GW-1:0] new_grp;
    grp_opt_t      new_opt, cur_opt;
    logic [GW-1:0] cur_grp;
    logic          cur_from_btn;
    logic          held;
    logic          accept;

    always_comb begin
        src     = SRC_NONE;
        new_grp = '0;
        if (key_press) begin
            src     = SRC_KEY;
            new_grp = key_grp;
        end else if (seq_press) begin
            src     = SRC_SEQ;
            new_grp = seq_ptr;
        end else if (strb_press) begin
            src     = SRC_STRB;
            new_grp = strb_grp;
        end
    end

    assign new_opt = '{is_edge: opt_edge[new_grp], holdable: opt_hold[new_grp],
                       retrig: opt_retrig[new_grp]};
    assign cur_opt = '{is_edge: opt_edge[cur_grp], holdable: opt_hold[cur_grp],
                       retrig: opt_retrig[cur_grp]};

    assign held   = cur_from_btn ? btn_now : (key_now_valid && key_now_grp == cur_grp);
    assign accept = (src != SRC_NONE) && (!active || may_overlap(new_opt));
    assign hold_active = active && cur_opt.holdable && held;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_pulse  <= 1'b0;
            start_grp    <= '0;
            stop_req     <= 1'b0;
            active       <= 1'b0;
            cur_grp      <= '0;
            cur_from_btn <= 1'b0;
            seq_ptr      <= '0;
        end else begin
            start_pulse <= 1'b0;
            stop_req    <= 1'b0;
            if (accept) begin
                start_pulse  <= 1'b1;
                start_grp    <= new_grp;
                cur_grp      <= new_grp;
                cur_from_btn <= (src != SRC_KEY);
                active       <= 1'b1;
                if (src == SRC_SEQ) begin
                    seq_ptr <= (seq_ptr == GW'(SEQ_LEN - 1)) ? '0 : seq_ptr + 1'b1;
                end
            end else if (active && play_done) begin
                if (!cur_opt.is_edge && held) begin
                    start_pulse <= 1'b1;
                    start_grp   <= cur_grp;
                end else begin
                    active <= 1'b0;
                end
            end else if (active && cur_opt.holdable && !held) begin
                stop_req <= 1'b1;
                active   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/trig_ctl.sv
module trig_ctl
    import trig_pkg::*;
#(
    parameter int NGROUPS      = DEF_GROUPS,
    parameter int NPINS        = DEF_PINS,
    parameter int SEQ_LEN      = DEF_SEQ_LEN,
    parameter int DEB_TICKS    = DEF_DEB_TICKS,
    parameter int RETRIG_TICKS = DEF_RETRIG_TICKS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_strobe_mode,
    input  logic                       sample_tick,
    input  logic [NPINS-1:0]           key_pins,
    input  logic                       seq_btn,
    input  logic                       play_done,
    input  logic [NGROUPS-1:0]         opt_edge,
    input  logic [NGROUPS-1:0]         opt_hold,
    input  logic [NGROUPS-1:0]         opt_retrig,
    output logic                       start_pulse,
    output logic [$clog2(NGROUPS)-1:0] start_grp,
    output logic                       stop_req,
    output logic                       hold_active
);
    localparam int GW = $clog2(NGROUPS);
    localparam int VW = NPINS + 1;

    logic [VW-1:0] raw_q, deb_vec, deb_prev;
    logic          play_active;
    logic [GW-1:0] seq_ptr;
    logic          now_valid, prev_valid;
    logic [GW-1:0] now_grp, prev_grp;
    logic          btn_rise;
    logic          key_press, seq_press, strb_press;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q    <= '0;
            deb_prev <= '0;
        end else begin
            raw_q    <= {seq_btn, key_pins};
            deb_prev <= deb_vec;
        end
    end

    trig_debounce #(
        .W(VW), .DEB_TICKS(DEB_TICKS), .RETRIG_TICKS(RETRIG_TICKS)
    ) u_deb (
        .clk(clk), .rst(rst), .tick(sample_tick), .long_win(play_active),
        .raw(raw_q), .deb(deb_vec)
    );

    trig_decode #(.NPINS(NPINS), .GW(GW)) u_dec_now (
        .pins(deb_vec[NPINS-1:0]), .valid(now_valid), .grp(now_grp)
    );

    trig_decode #(.NPINS(NPINS), .GW(GW)) u_dec_prev (
        .pins(deb_prev[NPINS-1:0]), .valid(prev_valid), .grp(prev_grp)
    );

    assign btn_rise   = deb_vec[NPINS] && !deb_prev[NPINS];
    assign key_press  = !cfg_strobe_mode && now_valid && (!prev_valid || prev_grp != now_grp);
    assign seq_press  = !cfg_strobe_mode && btn_rise;
    assign strb_press = cfg_strobe_mode && btn_rise;

    trig_sequencer #(.NGROUPS(NGROUPS), .SEQ_LEN(SEQ_LEN), .GW(GW)) u_seq (
        .clk(clk), .rst(rst),
        .key_press(key_press), .key_grp(now_grp),
        .seq_press(seq_press),
        .strb_press(strb_press), .strb_grp(deb_vec[GW-1:0]),
        .key_now_valid(now_valid && !cfg_strobe_mode), .key_now_grp(now_grp),
        .btn_now(deb_vec[NPINS]),
        .play_done(play_done),
        .opt_edge(opt_edge), .opt_hold(opt_hold), .opt_retrig(opt_retrig),
        .start_pulse(start_pulse), .start_grp(start_grp),
        .stop_req(stop_req), .hold_active(hold_active),
        .active(play_active), .seq_ptr(seq_ptr)
    );

endmodule

// File: rtl/trig_ctl_chk.sv
module trig_ctl_chk #(
    parameter int W       = 9,
    parameter int GW      = 5,
    parameter int SEQ_LEN = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          sample_tick,
    input logic          cfg_strobe_mode,
    input logic [W-1:0]  deb_vec,
    input logic [GW-1:0] seq_ptr,
    input logic          active,
    input logic          start_pulse,
    input logic          stop_req,
    input logic          hold_active
);
    // R6: debounced vector only moves on a sample tick
    p_deb_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> $stable(deb_vec));

    // R4: pointer frozen in strobe mode
    p_ptr_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_strobe_mode |=> $stable(seq_ptr));

    // R4: pointer stays inside the sequential range
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (rst)
        seq_ptr < GW'(SEQ_LEN));

    // R8: stop and start never in the same cycle
    p_no_start_stop_r8: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && stop_req));

    // R8: a stop leaves nothing held or active
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> (!active && !hold_active));

    // R10: hold indication only while active
    p_hold_in_play_r10: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> active);

    // R9: every start leaves playback active
    p_start_active_r9: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> active);

endmodule

bind trig_ctl trig_ctl_chk #(
    .W(NPINS + 1), .GW($clog2(NGROUPS)), .SEQ_LEN(SEQ_LEN)
) u_chk (
    .clk(clk), .rst(rst), .sample_tick(sample_tick),
    .cfg_strobe_mode(cfg_strobe_mode), .deb_vec(deb_vec), .seq_ptr(seq_ptr),
    .active(play_active), .start_pulse(start_pulse), .stop_req(stop_req),
    .hold_active(hold_active)
);

// File: tb/trig_ctl_test.sv
`timescale 1ns/1ps
module trig_ctl_test;
    localparam int DEB = 128;
    localparam int RET = 192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_strobe_mode = 1'b0;
    logic        sample_tick = 1'b1;
    logic [7:0]  key_pins = '0;
    logic        seq_btn = 1'b0;
    logic        play_done = 1'b0;
    logic [31:0] opt_edge, opt_hold, opt_retrig;
    logic        start_pulse, stop_req, hold_active;
    logic [4:0]  start_grp;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    trig_ctl uut (
        .clk(clk), .rst(rst), .cfg_strobe_mode(cfg_strobe_mode),
        .sample_tick(sample_tick), .key_pins(key_pins), .seq_btn(seq_btn),
        .play_done(play_done), .opt_edge(opt_edge), .opt_hold(opt_hold),
        .opt_retrig(opt_retrig), .start_pulse(start_pulse), .start_grp(start_grp),
        .stop_req(stop_req), .hold_active(hold_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected key-mode group for a pin pattern; -1 when none
    function automatic int exp_key(input logic [7:0] p);
        int low;
        low = -1;
        for (int i = 7; i >= 0; i--) if (p[i]) low = i;
        if (low < 0) return -1;
        if (p == (8'd1 << low)) return low;
        if (low < 7 && p == (8'd3 << low)) return 8 + low;
        return -1;
    endfunction

    task automatic wait_start(input int maxc, output bit found, output int grp, output int lat);
        found = 0; grp = -1; lat = 0;
        while (lat < maxc && !found) begin
            @(negedge clk);
            lat++;
            if (start_pulse) begin
                found = 1;
                grp = int'(start_grp);
            end
        end
    endtask

    task automatic wait_stop(input int maxc, output bit found, output int lat);
        found = 0; lat = 0;
        while (lat < maxc && !found) begin
            @(negedge clk);
            lat++;
            if (stop_req) found = 1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Returns 1 if start_pulse is seen in the cycle after the done pulse
    task automatic pulse_done(output bit restarted);
        play_done = 1'b1;
        @(negedge clk);
        play_done = 1'b0;
        restarted = start_pulse;
    endtask

    task automatic finish_play(input string req);
        bit r;
        key_pins = '0;
        seq_btn  = 1'b0;
        idle(RET + 12);
        pulse_done(r);
        chk(!r, req, int'(r), 0);
        idle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        bit found, r;
        int grp, lat, e;
        logic [7:0] code;
        int addrs[6];

        // default: edge, unholdable, non-retriggerable
        opt_edge = '1; opt_hold = '0; opt_retrig = '0;
        opt_edge[1] = 1'b0;                      // level unholdable
        opt_retrig[3] = 1'b1;                    // edge retriggerable
        opt_edge[4] = 1'b0; opt_hold[4] = 1'b1;  // level holdable
        opt_edge[5] = 1'b0;                      // level unholdable

        void'($urandom(32'd2024));
        idle(3);
        rst = 1'b0;
        idle(2);

        // R1 reset state
        chk(!start_pulse, "R1 start low", int'(start_pulse), 0);
        chk(!stop_req, "R1 stop low", int'(stop_req), 0);
        chk(!hold_active, "R1 hold low", int'(hold_active), 0);

        // R4 / R1 sequential stepping with wrap
        for (int i = 0; i < 17; i++) begin
            seq_btn = 1'b1;
            wait_start(DEB + 10, found, grp, lat);
            chk(found && grp == i % 16, (i == 0) ? "R1 first seq index" : "R4 seq index",
                grp, i % 16);
            finish_play("R9 no restart after release");
        end

        // R3 directed pairs and a non-adjacent pair
        key_pins = 8'hC0;
        wait_start(DEB + 10, found, grp, lat);
        chk(found && grp == 14, "R3 top pair", grp, 14);
        finish_play("R9 idle");
        key_pins = 8'h05;
        wait_start(DEB + 20, found, grp, lat);
        chk(!found, "R3 non-adjacent ignored", int'(found), 0);
        finish_play("R9 idle");

        // R6 short glitch is lost
        key_pins = 8'h04;
        idle(60);
        key_pins = 8'h00;
        wait_start(DEB + 200, found, grp, lat);
        chk(!found, "R6 glitch ignored", int'(found), 0);

        // R6 no tick, no progress
        sample_tick = 1'b0;
        key_pins = 8'h01;
        wait_start(400, found, grp, lat);
        chk(!found, "R6 no tick no accept", int'(found), 0);
        sample_tick = 1'b1;
        wait_start(DEB + 10, found, grp, lat);
        chk(found && grp == 0, "R6 accept after ticks resume", grp, 0);

        // R7 overlap rules; R6 long window while active
        key_pins = 8'h02;
        wait_start(RET + 10, found, grp, lat);
        chk(found && grp == 1, "R7 level unholdable overlaps", grp, 1);
        chk(lat >= RET + 1 && lat <= RET + 5, "R6 retrigger window", lat, RET + 3);
        key_pins = 8'h04;
        wait_start(RET + 60, found, grp, lat);
        chk(!found, "R7 edge non-retrig ignored", int'(found), 0);
        key_pins = 8'h08;
        wait_start(RET + 10, found, grp, lat);
        chk(found && grp == 3, "R7 edge retrig restarts", grp, 3);
        finish_play("R9 edge no restart");

        // R8 / R10 holdable release stops
        key_pins = 8'h10;
        wait_start(DEB + 10, found, grp, lat);
        chk(found && grp == 4, "R2 pin 4", grp, 4);
        chk(lat >= DEB + 1 && lat <= DEB + 5, "R6 idle window", lat, DEB + 3);
        idle(3);
        chk(hold_active, "R10 hold while held", int'(hold_active), 1);
        key_pins = 8'h00;
        wait_stop(RET + 10, found, lat);
        chk(found, "R8 stop on release", int'(found), 1);
        chk(!hold_active, "R10 hold drops", int'(hold_active), 0);
        pulse_done(r);
        chk(!r, "R8 done after stop ignored", int'(r), 0);
        idle(DEB + 10);

        // R9 level loops while held; edge does not
        key_pins = 8'h20;
        wait_start(DEB + 10, found, grp, lat);
        chk(found && grp == 5, "R2 pin 5", grp, 5);
        idle(5);
        chk(!hold_active, "R10 unholdable shows no hold", int'(hold_active), 0);
        pulse_done(r);
        chk(r && start_grp == 5, "R9 level restart", int'(start_grp), 5);
        finish_play("R9 release then done");
        key_pins = 8'h40;
        wait_start(DEB + 10, found, grp, lat);
        chk(found && grp == 6, "R2 pin 6", grp, 6);
        idle(5);
        pulse_done(r);
        chk(!r, "R9 edge no loop", int'(r), 0);
        finish_play("R9 idle");

        // Random key patterns (R2 / R3)
        for (int t = 0; t < 30; t++) begin
            case ($urandom % 3)
                0: code = 8'd1 << ($urandom % 8);
                1: code = 8'd3 << ($urandom % 7);
                default: code = 8'($urandom % 256);
            endcase
            e = exp_key(code);
            key_pins = code;
            wait_start(DEB + 10, found, grp, lat);
            if (e < 0) chk(!found, "R3 random invalid", grp, -1);
            else chk(found && grp == e, (e < 8) ? "R2 random single" : "R3 random pair", grp, e);
            finish_play("R9 random idle");
        end

        // R5 strobe mode
        cfg_strobe_mode = 1'b1;
        idle(4);
        key_pins = 8'h01;
        wait_start(DEB + 100, found, grp, lat);
        chk(!found, "R5 pins alone ignored", int'(found), 0);
        addrs = '{0, 31, 17, 5, int'($urandom % 32), int'($urandom % 32)};
        foreach (addrs[k]) begin
            key_pins = 8'(addrs[k]);
            idle(3);
            seq_btn = 1'b1;
            wait_start(DEB + 10, found, grp, lat);
            chk(found && grp == addrs[k], "R5 strobe address", grp, addrs[k]);
            finish_play("R9 strobe idle");
        end
        cfg_strobe_mode = 1'b0;
        idle(4);

        // R4 pointer unchanged by strobe mode (17 steps earlier leave it at 1)
        seq_btn = 1'b1;
        wait_start(DEB + 10, found, grp, lat);
        chk(found && grp == 1, "R4 pointer kept across strobe mode", grp, 1);
        finish_play("R9 idle");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule